// File: doc/BRIEF.md
# Per-Channel Sign-Magnitude Offset and Linear Gain Correction Stage

This block corrects a stream of unsigned pixel samples, one colour channel at a time. Each sample arrives with a valid strobe and a two-bit channel tag. The tag picks one of three register pairs: red, green or blue. The sample first gets a signed offset. The offset is held as an 8-bit sign-magnitude code, and its magnitude is scaled up to input LSBs by a fixed left shift. The offset-corrected value is then multiplied by a linear gain of 1 + code/51.2, rounded to nearest and clamped to the output range. The result leaves the block two clock cycles later, together with the delayed valid and tag.

The register pairs are loaded through a simple write strobe port. A write becomes visible to samples presented in the following cycle. A sample picks up its offset and its gain code in the same cycle, so it never uses a mix of old and new settings, even when a write lands while the sample is inside the pipeline.

Top module: `pix_trim_stage`

## Requirements
- R1: The offset code bit 7 is the sign (0 adds, 1 subtracts) and bits 6..0 are the magnitude. The applied offset is magnitude << OFS_SHIFT input LSBs (OFS_SHIFT = 2 by default).
- R2: Offset codes 0x00 and 0x80 both leave the sample unchanged by the offset step.
- R3: Code 0x7F adds, and code 0xFF subtracts, the same largest offset (127 << OFS_SHIFT).
- R4: With offset-corrected value a and gain code g, the output is (a*256 + a*g*5 + 128) >> 8, which is a*(1 + g/51.2) rounded to nearest. Gain code 0 gives unity gain.
- R5: The offset is applied before the gain, so the gain also scales the offset.
- R6: The output saturates at 0 and at 2^DATA_W - 1 (1023 by default) and never wraps.
- R7: Channel tag 0 selects the red registers, 1 green and 2 blue. Tag 3 applies zero offset and unity gain.
- R8: A sample presented before clock edge k appears on the outputs after edge k+1. out_valid and out_ch follow in_valid and in_ch with the same two-cycle delay.
- R9: A write with cfg_we=1 stores cfg_code into the offset register (cfg_is_gain=0) or the gain register (cfg_is_gain=1) of channel cfg_ch. Only samples presented in later cycles see the write, and a sample already in flight keeps the offset and gain it started with. Writes to cfg_ch=3 are ignored.
- R10: After reset out_valid is 0 and every offset and gain register holds 0, so samples pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Unsigned input sample |
| in_ch | input | 2 | Channel tag of the input sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel to write |
| cfg_is_gain | input | 1 | 1 selects the gain register, 0 selects the offset register |
| cfg_code | input | 8 | Code to store |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Corrected, saturated sample |
| out_ch | output | 2 | Channel tag of the output sample |

## Verification
Directed samples cover both zero codes, both extreme offset codes, gain codes 0 and 255, and samples that push the result past either rail. Together they separate sign handling, magnitude scaling and clamping. A sample with a positive offset and a large gain tells the offset-then-gain order apart from the reverse order. Writes that land in the same cycle as a sample, or while the sample sits in the first stage, expose any tearing between old and new settings. A long stretch of random samples, tags and interleaved writes then checks the rounding of the multiply and the per-channel selection against a model in the bench.

// File: rtl/pix_trim_pkg.sv
package pix_trim_pkg;
   localparam int CODE_W = 8;
   localparam int TAG_W  = 2;
   typedef enum logic [TAG_W-1:0] {
      TAG_RED  = 2'd0,
      TAG_GRN  = 2'd1,
      TAG_BLU  = 2'd2,
      TAG_NONE = 2'd3
   } chan_tag_e;
endpackage

// File: rtl/pix_trim_regs.sv
module pix_trim_regs
   import pix_trim_pkg::*;
#(
   parameter int NCH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [TAG_W-1:0]  cfg_ch,
   input  logic              cfg_is_gain,
   input  logic [CODE_W-1:0] cfg_code,
   input  logic [TAG_W-1:0]  rd_ch,
   output logic [CODE_W-1:0] rd_ofs,
   output logic [CODE_W-1:0] rd_gain
);
   logic [CODE_W-1:0] ofs_q  [NCH];
   logic [CODE_W-1:0] gain_q [NCH];

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ofs_q[g]  <= '0;
            gain_q[g] <= '0;
         end else if (cfg_we && cfg_ch == TAG_W'(g)) begin
            if (cfg_is_gain) gain_q[g] <= cfg_code;
            else             ofs_q[g]  <= cfg_code;
         end
      end

      // R9: a register only changes on a write addressed to it
      p_hold_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_we && cfg_ch == TAG_W'(g) && !cfg_is_gain) |=> $stable(ofs_q[g]));
      p_hold_gain_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_we && cfg_ch == TAG_W'(g) && cfg_is_gain) |=> $stable(gain_q[g]));
   end

   // unmapped tags read as zero offset and unity gain
   always_comb begin
      rd_ofs  = '0;
      rd_gain = '0;
      for (int i = 0; i < NCH; i++) begin
         if (rd_ch == TAG_W'(i)) begin
            rd_ofs  = ofs_q[i];
            rd_gain = gain_q[i];
         end
      end
   end
endmodule

// File: rtl/pix_trim_offset.sv
module pix_trim_offset
   import pix_trim_pkg::*;
#(
   parameter int DATA_W    = 10,
   parameter int OFS_SHIFT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [TAG_W-1:0]  in_ch,
   input  logic [CODE_W-1:0] ofs_code,
   input  logic [CODE_W-1:0] gain_code,
   output logic              s1_valid,
   output logic [DATA_W-1:0] s1_adj,
   output logic [TAG_W-1:0]  s1_ch,
   output logic [CODE_W-1:0] s1_gain
);
   localparam int SW = DATA_W + 2;
   localparam logic signed [SW-1:0] MAXV = SW'((1 << DATA_W) - 1);

   logic [SW-1:0]        mag;
   logic signed [SW-1:0] sum;
   logic [DATA_W-1:0]    adj;

   if (OFS_SHIFT == 0) begin : g_noshift
      assign mag = SW'(ofs_code[CODE_W-2:0]);
   end else begin : g_shift
      assign mag = SW'(ofs_code[CODE_W-2:0]) << OFS_SHIFT;
   end

   always_comb begin
      if (ofs_code[CODE_W-1]) sum = $signed(SW'(in_data)) - $signed(mag);
      else                    sum = $signed(SW'(in_data)) + $signed(mag);
      if (sum < 0)          adj = '0;
      else if (sum > MAXV)  adj = MAXV[DATA_W-1:0];
      else                  adj = sum[DATA_W-1:0];
   end

   // offset and gain code are captured together: no torn settings
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_adj   <= '0;
         s1_ch    <= '0;
         s1_gain  <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_adj   <= adj;
         s1_ch    <= in_ch;
         s1_gain  <= gain_code;
      end
   end

   p_zero_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ofs_code[CODE_W-2:0] == '0) |=> s1_adj == $past(in_data));
   p_pos_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ofs_code[CODE_W-1]) |=> s1_adj >= $past(in_data));
   p_neg_shrinks_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ofs_code[CODE_W-1]) |=> s1_adj <= $past(in_data));
   p_stage1_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s1_valid);
endmodule

// File: rtl/pix_trim_gain.sv
module pix_trim_gain
   import pix_trim_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter bit ROUND  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s1_valid,
   input  logic [DATA_W-1:0] s1_adj,
   input  logic [TAG_W-1:0]  s1_ch,
   input  logic [CODE_W-1:0] s1_gain,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [TAG_W-1:0]  out_ch
);
   localparam int PW = DATA_W + 12;
   localparam int QW = PW - 8;
   localparam logic [QW-1:0] MAXQ = QW'((1 << DATA_W) - 1);

   logic [PW-1:0] bias;
   logic [PW-1:0] prod;
   logic [QW-1:0] q;
   logic [DATA_W-1:0] sat;

   if (ROUND) begin : g_round
      assign bias = PW'(128);
   end else begin : g_trunc
      assign bias = '0;
   end

   // x*(1 + g/51.2) == (x*256 + x*g*5) / 256
   assign prod = (PW'(s1_adj) << 8) + PW'(s1_adj) * PW'(s1_gain) * PW'(5) + bias;
   assign q    = prod[PW-1:8];

   always_comb begin
      if (q > MAXQ) sat = MAXQ[DATA_W-1:0];
      else          sat = q[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ch    <= '0;
      end else begin
         out_valid <= s1_valid;
         out_data  <= sat;
         out_ch    <= s1_ch;
      end
   end

   p_unity_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_gain == '0) |=> out_data == $past(s1_adj));
   p_no_shrink_r6: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_data >= $past(s1_adj));
   p_valid_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_valid);
   p_valid_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !out_valid);
   p_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_ch == $past(s1_ch));
endmodule

// File: rtl/pix_trim_stage.sv
module pix_trim_stage
   import pix_trim_pkg::*;
#(
   parameter int DATA_W    = 10,
   parameter int OFS_SHIFT = 2,
   parameter bit ROUND     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [1:0]        in_ch,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_ch,
   input  logic              cfg_is_gain,
   input  logic [7:0]        cfg_code,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [1:0]        out_ch
);
   localparam int NCH = 3;

   if (DATA_W < 8 || DATA_W > 16) begin : g_bad_width
      $error("pix_trim_stage: DATA_W must lie in 8..16");
   end
   if (OFS_SHIFT < 0 || OFS_SHIFT + CODE_W - 1 > DATA_W) begin : g_bad_shift
      $error("pix_trim_stage: scaled offset magnitude must fit in DATA_W");
   end

   logic [CODE_W-1:0] rd_ofs, rd_gain;
   logic              s1_valid;
   logic [DATA_W-1:0] s1_adj;
   logic [TAG_W-1:0]  s1_ch;
   logic [CODE_W-1:0] s1_gain;

   pix_trim_regs #(.NCH(NCH)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_is_gain(cfg_is_gain), .cfg_code(cfg_code),
      .rd_ch(in_ch), .rd_ofs(rd_ofs), .rd_gain(rd_gain)
   );

   pix_trim_offset #(.DATA_W(DATA_W), .OFS_SHIFT(OFS_SHIFT)) u_offset (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_ch(in_ch),
      .ofs_code(rd_ofs), .gain_code(rd_gain),
      .s1_valid(s1_valid), .s1_adj(s1_adj), .s1_ch(s1_ch), .s1_gain(s1_gain)
   );

   pix_trim_gain #(.DATA_W(DATA_W), .ROUND(ROUND)) u_gain (
      .clk(clk), .rst_n(rst_n),
      .s1_valid(s1_valid), .s1_adj(s1_adj), .s1_ch(s1_ch), .s1_gain(s1_gain),
      .out_valid(out_valid), .out_data(out_data), .out_ch(out_ch)
   );

   // R7: tag 3 carries no correction through the pipeline
   p_none_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ch == TAG_NONE) |=> (s1_adj == $past(in_data) && s1_gain == '0));
endmodule

// File: tb/pix_trim_stage_bench.sv
module pix_trim_stage_bench;
   localparam int DW   = 10;
   localparam int SH   = 2;
   localparam int MAXV = (1 << DW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic [1:0] in_ch = '0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_ch = '0;
   logic cfg_is_gain = 1'b0;
   logic [7:0] cfg_code = '0;
   logic out_valid;
   logic [DW-1:0] out_data;
   logic [1:0] out_ch;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0] m_ofs [4];
   logic [7:0] m_gain [4];

   bit    p_v = 1'b0;
   int    p_d = 0;
   int    p_c = 0;
   string p_tag = "R10";

   always #10 clk = ~clk;

   pix_trim_stage #(.DATA_W(DW), .OFS_SHIFT(SH)) u_pix_trim_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_ch(in_ch),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_is_gain(cfg_is_gain), .cfg_code(cfg_code),
      .out_valid(out_valid), .out_data(out_data), .out_ch(out_ch)
   );

   function automatic int model(int x, logic [7:0] o, logic [7:0] g);
      longint m, s, p;
      m = longint'(o[6:0]) << SH;
      s = o[7] ? x - m : x + m;
      if (s < 0) s = 0;
      if (s > MAXV) s = MAXV;
      p = (s * 256 + s * longint'(g) * 5 + 128) >> 8;
      if (p > MAXV) p = MAXV;
      return int'(p);
   endfunction

   task automatic step(bit v, int x, int ch, bit we, int wch, bit wg, int wcode, string tag);
      bit c_v;
      int c_d;
      in_valid    = v;
      in_data     = DW'(x);
      in_ch       = 2'(ch);
      cfg_we      = we;
      cfg_ch      = 2'(wch);
      cfg_is_gain = wg;
      cfg_code    = 8'(wcode);
      c_v = v;
      c_d = model(x, m_ofs[ch], m_gain[ch]);
      @(posedge clk);
      if (we && wch != 3) begin
         if (wg) m_gain[wch] = 8'(wcode);
         else    m_ofs[wch]  = 8'(wcode);
      end
      @(negedge clk);
      total++;
      if (out_valid !== p_v || (p_v && (out_data !== DW'(p_d) || out_ch !== 2'(p_c)))) begin
         bad++;
         $display("FAIL %s: valid=%0b data=%0d ch=%0d expected valid=%0b data=%0d ch=%0d",
                  p_tag, out_valid, out_data, out_ch, p_v, p_d, p_c);
      end
      p_v = c_v; p_d = c_d; p_c = ch; p_tag = tag;
   endtask

   task automatic smp(int x, int ch, string tag);
      step(1'b1, x, ch, 1'b0, 0, 1'b0, 0, tag);
   endtask

   task automatic wr(int wch, bit wg, int code, string tag);
      step(1'b0, 0, 0, 1'b1, wch, wg, code, tag);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin m_ofs[i] = '0; m_gain[i] = '0; end
      repeat (3) @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin
         bad++;
         $display("FAIL R10: out_valid=%0b in reset expected 0", out_valid);
      end
      rst_n = 1'b1;
      // R10: registers cleared, samples pass unchanged
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, "R10");
      smp(300, 0, "R10"); smp(511, 1, "R10"); smp(1023, 2, "R10");
      // R1: sign and scaled magnitude
      wr(0, 1'b0, 8'h05, "R1"); smp(100, 0, "R1");
      wr(1, 1'b0, 8'h85, "R1"); smp(100, 1, "R1");
      // R2: both zero codes
      wr(2, 1'b0, 8'h80, "R2"); smp(555, 2, "R2");
      wr(2, 1'b0, 8'h00, "R2"); smp(555, 2, "R2");
      // R3: extreme codes
      wr(0, 1'b0, 8'h7F, "R3"); smp(200, 0, "R3");
      wr(0, 1'b0, 8'hFF, "R3"); smp(600, 0, "R3");
      // R4: gain codes and rounding
      wr(1, 1'b0, 8'h00, "R4"); wr(1, 1'b1, 8'd255, "R4"); smp(100, 1, "R4");
      wr(1, 1'b1, 8'd1, "R4"); smp(77, 1, "R4"); smp(26, 1, "R4");
      wr(1, 1'b1, 8'd0, "R4"); smp(333, 1, "R4");
      // R5: offset before gain (140*3.5=490, not 390)
      wr(1, 1'b0, 8'h0A, "R5"); wr(1, 1'b1, 8'd128, "R5"); smp(100, 1, "R5");
      // R6: both rails
      smp(1000, 1, "R6"); smp(10, 0, "R6"); smp(0, 0, "R6");
      // R7: tag 3 and channel separation
      smp(777, 3, "R7"); smp(400, 0, "R7"); smp(400, 1, "R7"); smp(400, 2, "R7");
      // R8: back-to-back, gaps
      smp(1, 2, "R8"); smp(2, 1, "R8");
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, "R8"); smp(3, 0, "R8");
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, "R8"); step(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, "R8");
      // R9: write in the same cycle as a sample, then while it is in stage 1
      wr(2, 1'b0, 8'h00, "R9"); wr(2, 1'b1, 8'd0, "R9");
      step(1'b1, 500, 2, 1'b1, 2, 1'b1, 200, "R9");
      step(1'b1, 500, 2, 1'b1, 2, 1'b0, 8'hFF, "R9");
      smp(500, 2, "R9");
      wr(3, 1'b0, 8'h7F, "R9"); wr(3, 1'b1, 8'd255, "R9");
      smp(321, 3, "R9");
      // random traffic
      for (int n = 0; n < 2000; n++) begin
         bit v, we, wg;
         int x, ch, wch, code;
         v    = ($urandom % 10) < 7;
         x    = $urandom % (MAXV + 1);
         ch   = $urandom % 4;
         we   = ($urandom % 8) == 0;
         wch  = $urandom % 4;
         wg   = $urandom % 2;
         code = $urandom % 256;
         if (($urandom % 16) == 0) x = (($urandom % 2) == 0) ? 0 : MAXV;
         step(v, x, ch, we, wch, wg, code, "R4");
      end
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, "R8");
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 0, "R8");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R8: watchdog expired, actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule